// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block turns processor virtual addresses into physical addresses for one load/store port. It keeps a small, fully associative set of translations. Each set holds a virtual page number, a physical page number, access permissions for user and supervisor code, a mapped flag and a cacheable flag, plus accessed and dirty status. A request compares its page number against every valid set at once. On a permitted hit, the physical page number is joined to the untouched page offset, and the result appears one clock later. When nothing matches, the block reports a miss. When the matching set forbids the access, or has no frame behind it, the block reports a page fault.

Translations come in through a refill port, driven by software or by an external table walker. A refill whose page number is already held replaces that set. Otherwise the refill goes to a victim chosen from the valid and accessed bits, so that recently used translations survive. A single flush input drops every translation in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. All response fields are registered and describe the request of the previous cycle.
- R2: On a permitted hit, `rsp_paddr` equals {stored physical page, `req_vaddr[11:0]`}. `rsp_cacheable` equals the set's cacheable bit (`fill_attr[5]`).
- R3: When no valid set holds the request's page number (`req_vaddr[31:12]`), `rsp_miss` is 1. In that case `rsp_fault`, `rsp_paddr`, `rsp_cacheable` and `rsp_dirty` are 0.
- R4: `fill_attr` bits are [0] user read, [1] user write, [2] supervisor read, [3] supervisor write. A hit whose permission bit for (`req_super`, `req_write`) is 0 gives `rsp_fault`=1 with `rsp_paddr`, `rsp_cacheable` and `rsp_dirty` at 0.
- R5: A hit on a set whose mapped bit (`fill_attr[4]`) is 0 faults for every access type.
- R6: A permitted write hit sets the set's dirty bit. `rsp_dirty` gives the dirty bit as it stands after the access. A refill clears the dirty bit.
- R7: A faulting access changes neither the accessed bits nor the dirty bits.
- R8: A permitted hit sets the set's accessed bit. If that would leave every accessed bit set, all other accessed bits clear instead. A refill of a new page goes to the lowest-index invalid set. If no set is invalid, it goes to the lowest-index set whose accessed bit is clear. The refilled set starts with accessed clear.
- R9: A refill whose page number matches a valid set overwrites that set. No duplicate is created.
- R10: `flush_all` invalidates every set and clears all accessed bits at the next edge. A refill in the same cycle is discarded. A lookup in the same cycle still sees the old contents.
- R11: A refill takes effect at the clock edge. A lookup in the same cycle sees the contents from before the refill.
- R12: After reset, every set is invalid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store, 0 = load |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_attr | input | 6 | Permission, mapped and cacheable bits |
| flush_all | input | 1 | Invalidate all translations |
| rsp_valid | output | 1 | Response strobe |
| rsp_miss | output | 1 | No matching translation |
| rsp_fault | output | 1 | Access refused by the matching set |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the matching set |
| rsp_dirty | output | 1 | Dirty flag of the matching set after the access |

## Verification
The first pattern sweeps all 64 attribute codes on one page. Each code is hit with the four combinations of privilege and direction. This separates every permission bit, shows the mapped flag overriding them all, and shows the dirty bit appearing only after a permitted store. Directed sequences fill every set and then fault on the one set not yet touched. This shows whether a fault leaks into the accessed bits, and separately whether the wrap clear of those bits happens at all. Further directed cycles pair a refill with a flush or a lookup in the same cycle, which reveals the priority order. A long pseudo-random stream over sixteen pages, double the set count, forces evictions, refills of pages already held, and mixed permissions, all checked against an arithmetic model of the victim choice.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Bit order gives usr_rd at bit 0 and cache_ok at bit 5.
  typedef struct packed {
    logic cache_ok;
    logic mapped;
    logic sup_wr;
    logic sup_rd;
    logic usr_wr;
    logic usr_rd;
  } xlat_attr_t;

  function automatic logic xlat_refused(xlat_attr_t a, logic is_sup, logic is_wr);
    logic ok;
    if (!a.mapped)   ok = 1'b0;
    else if (is_sup) ok = is_wr ? a.sup_wr : a.sup_rd;
    else             ok = is_wr ? a.usr_wr : a.usr_rd;
    return !ok;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N = 8,
  parameter int W = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] tags,
  input  logic [N-1:0]        vld,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        hit_vec,
  output logic                any_hit,
  output logic [IW-1:0]       hit_idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  acc,
  output logic [IW-1:0] idx
);

  logic picked;

  always_comb begin
    idx    = '0;
    picked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!picked && !vld[i]) begin
        idx    = IW'(i);
        picked = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!picked && !acc[i]) begin
        idx    = IW'(i);
        picked = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PPN_W   = 20,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int PA_W   = PPN_W + PG_BITS,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int AT_W   = $bits(xlat_attr_t)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_super,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [AT_W-1:0]  fill_attr,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_cacheable,
  output logic             rsp_dirty
);

  // Translation storage: tags in flops for parallel compare, payload as arrays.
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [PPN_W-1:0]              ppn_q  [ENTRIES];
  xlat_attr_t                    attr_q [ENTRIES];
  logic [ENTRIES-1:0]            vld_q, acc_q, dirty_q;
  logic [ENTRIES-1:0]            vld_n, acc_n, dirty_n;

  // Lookup side
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_hit;
  logic [IW-1:0]      lk_idx;
  xlat_attr_t         lk_attr;
  logic               lk_refused, grant;

  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_lookup (
    .tags(tag_q), .vld(vld_q), .key(req_vaddr[VA_W-1:PG_BITS]),
    .hit_vec(lk_vec), .any_hit(lk_hit), .hit_idx(lk_idx)
  );

  assign lk_attr    = attr_q[lk_idx];
  assign lk_refused = xlat_refused(lk_attr, req_super, req_write);
  assign grant      = req_valid && lk_hit && !lk_refused;

  // Refill side: an existing page is overwritten in place, else a victim is used.
  logic [ENTRIES-1:0] fl_vec;
  logic               fl_hit;
  logic [IW-1:0]      fl_idx, vic_idx, wr_idx;
  logic               fill_we;

  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_refill (
    .tags(tag_q), .vld(vld_q), .key(fill_vpn),
    .hit_vec(fl_vec), .any_hit(fl_hit), .hit_idx(fl_idx)
  );

  xlat_victim #(.N(ENTRIES)) u_victim (
    .vld(vld_q), .acc(acc_q), .idx(vic_idx)
  );

  assign wr_idx  = fl_hit ? fl_idx : vic_idx;
  assign fill_we = fill_valid && !flush_all;

  // Status bit update: hit first, then refill, then flush.
  always_comb begin
    vld_n   = vld_q;
    acc_n   = acc_q;
    dirty_n = dirty_q;
    if (grant) begin
      acc_n[lk_idx] = 1'b1;
      if (&acc_n) begin
        acc_n         = '0;
        acc_n[lk_idx] = 1'b1;
      end
      if (req_write) dirty_n[lk_idx] = 1'b1;
    end
    if (fill_we) begin
      vld_n[wr_idx]   = 1'b1;
      acc_n[wr_idx]   = 1'b0;
      dirty_n[wr_idx] = 1'b0;
    end
    if (flush_all) begin
      vld_n = '0;
      acc_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      acc_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_n;
      acc_q   <= acc_n;
      dirty_q <= dirty_n;
    end
  end

  // Payload written without reset, one port, so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[wr_idx]  <= fill_vpn;
      ppn_q[wr_idx]  <= fill_ppn;
      attr_q[wr_idx] <= xlat_attr_t'(fill_attr);
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_miss      <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      rsp_dirty     <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_miss      <= req_valid && !lk_hit;
      rsp_fault     <= req_valid && lk_hit && lk_refused;
      rsp_paddr     <= grant ? {ppn_q[lk_idx], req_vaddr[PG_BITS-1:0]} : '0;
      rsp_cacheable <= grant && lk_attr.cache_ok;
      rsp_dirty     <= grant && (dirty_q[lk_idx] || req_write);
    end
  end

  // Checks next to the logic they guard
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid)));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_miss && !rsp_fault)
      |-> (rsp_paddr[PG_BITS-1:0] == $past(req_vaddr[PG_BITS-1:0])));

  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (!rsp_fault && rsp_paddr == '0 && !rsp_cacheable && !rsp_dirty));

  a_r7_fault_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lk_hit && lk_refused && !fill_valid && !flush_all)
      |=> (acc_q == $past(acc_q) && dirty_q == $past(dirty_q)));

  a_r8_never_all_accessed: assert property (@(posedge clk) disable iff (rst)
    !(&acc_q));

  a_r8_free_slot_first: assert property (@(posedge clk) disable iff (rst)
    (fill_we && !fl_hit && !(&vld_q)) |-> !vld_q[vic_idx]);

  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec) && $onehot0(fl_vec));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_all)) |-> (vld_q == '0));

endmodule

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/1ps
module xlat_tlb_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_vaddr = '0;
  logic        fill_valid = 0, flush_all = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [5:0]  fill_attr = '0;
  logic        rsp_valid, rsp_miss, rsp_fault, rsp_cacheable, rsp_dirty;
  logic [31:0] rsp_paddr;

  xlat_tlb u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_cacheable(rsp_cacheable), .rsp_dirty(rsp_dirty)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Reference model of the sets
  logic [19:0] m_tag [N];
  logic [19:0] m_ppn [N];
  logic [5:0]  m_attr[N];
  bit          m_vld[N], m_acc[N], m_dirty[N];

  task automatic chk(string rq, string what, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit refuse(logic [5:0] a, bit sup, bit wr);
    if (!a[4]) return 1'b1;
    if (sup) return wr ? !a[3] : !a[2];
    return wr ? !a[1] : !a[0];
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock of stimulus, with the model advanced and outputs compared.
  task automatic step(string scen, bit rv, logic [31:0] va, bit wr, bit sup,
                      bit fv, logic [19:0] fvpn, logic [19:0] fppn,
                      logic [5:0] fat, bit fl);
    int hi, fi, mi;
    bit e_miss, e_fault, grant, e_cache, e_dirty, all;
    logic [31:0] e_pa;
    string rq;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_write = wr; req_super = sup;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_attr = fat;
    flush_all = fl;
    hi = -1;
    for (int i = 0; i < N; i++)
      if (hi < 0 && m_vld[i] && m_tag[i] == va[31:12]) hi = i;
    e_miss  = rv && hi < 0;
    e_fault = rv && hi >= 0 && refuse(m_attr[hi], sup, wr);
    grant   = rv && hi >= 0 && !e_fault;
    e_pa    = grant ? {m_ppn[hi], va[11:0]} : 32'h0;
    e_cache = grant && m_attr[hi][5];
    e_dirty = grant && (m_dirty[hi] || wr);
    mi = -1;
    for (int i = 0; i < N; i++)
      if (mi < 0 && m_vld[i] && m_tag[i] == fvpn) mi = i;
    fi = mi;
    for (int i = 0; i < N; i++) if (fi < 0 && !m_vld[i]) fi = i;
    for (int i = 0; i < N; i++) if (fi < 0 && !m_acc[i]) fi = i;
    if (fi < 0) fi = 0;
    @(posedge clk);
    #1;
    rq = e_miss ? "R3" : (e_fault ? (m_attr[hi][4] ? "R4" : "R5") : "R2");
    chk({scen, "/R1"}, "rsp_valid", rsp_valid, rv);
    chk({scen, "/", rq}, "rsp_miss", rsp_miss, e_miss);
    chk({scen, "/", rq}, "rsp_fault", rsp_fault, e_fault);
    chk({scen, "/", rq}, "rsp_paddr", rsp_paddr, e_pa);
    chk({scen, "/", rq}, "rsp_cacheable", rsp_cacheable, e_cache);
    chk({scen, "/R6"}, "rsp_dirty", rsp_dirty, e_dirty);
    if (grant) begin
      m_acc[hi] = 1;
      all = 1;
      for (int i = 0; i < N; i++) all &= m_acc[i];
      if (all) begin
        for (int i = 0; i < N; i++) m_acc[i] = 0;
        m_acc[hi] = 1;
      end
      if (wr) m_dirty[hi] = 1;
    end
    if (fv && !fl) begin
      m_vld[fi] = 1; m_acc[fi] = 0; m_dirty[fi] = 0;
      m_tag[fi] = fvpn; m_ppn[fi] = fppn; m_attr[fi] = fat;
    end
    if (fl) for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_acc[i] = 0; end
  endtask

  task automatic idle(string scen);
    step(scen, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(string scen, logic [19:0] vpn, logic [11:0] off, bit wr, bit sup);
    step(scen, 1, {vpn, off}, wr, sup, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string scen, logic [19:0] vpn, logic [19:0] ppn, logic [5:0] at);
    step(scen, 0, 0, 0, 0, 1, vpn, ppn, at, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_acc[i] = 0; m_dirty[i] = 0;
      m_tag[i] = 0; m_ppn[i] = 0; m_attr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12", "rsp_valid", rsp_valid, 0);
    chk("R12", "rsp_miss", rsp_miss, 0);
    chk("R12", "rsp_paddr", rsp_paddr, 0);
    @(negedge clk);
    rst = 0;
    look("R12", 20'h00000, 12'h000, 0, 0);
    look("R12", 20'hABCDE, 12'h123, 1, 1);

    // R4 R5 R6 R9: every attribute code on one page, all four access kinds
    for (int c = 0; c < 64; c++) begin
      fill("R9", 20'h12345, 20'(c * 3 + 7), 6'(c));
      look("R4", 20'h12345, 12'(c * 61), 0, 0);
      look("R4", 20'h12345, 12'(c * 17 + 1), 1, 0);
      look("R4", 20'h12345, 12'(c * 5 + 2), 0, 1);
      look("R6", 20'h12345, 12'hFFF, 1, 1);
      look("R6", 20'h12345, 12'h800, 0, 1);
    end

    // R10: flush with a same-cycle lookup and a same-cycle refill
    step("R10", 1, {20'h12345, 12'h010}, 0, 1, 1, 20'h00077, 20'h00055, 6'h3F, 1);
    look("R10", 20'h12345, 12'h010, 0, 1);
    look("R10", 20'h00077, 12'h010, 0, 1);

    // R11: refill and lookup of the same page in one cycle
    step("R11", 1, {20'h00ABC, 12'h444}, 0, 0, 1, 20'h00ABC, 20'h0F00F, 6'h1F, 0);
    look("R11", 20'h00ABC, 12'h444, 0, 0);

    // R7 R8: fill every set, touch all but the last, fault on the last
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < N; i++)
      fill("R8", 20'h00100 + 20'(i), 20'h00200 + 20'(i), (i == N - 1) ? 6'h1C : 6'h3F);
    for (int i = 0; i < N - 1; i++) look("R8", 20'h00100 + 20'(i), 12'h004, 0, 0);
    look("R7", 20'h00107, 12'h008, 0, 0);
    look("R7", 20'h00107, 12'h008, 1, 0);
    fill("R7", 20'h00300, 20'h00333, 6'h3F);
    look("R7", 20'h00107, 12'h00C, 0, 1);
    look("R7", 20'h00100, 12'h00C, 0, 0);
    // R8: wrap of the accessed bits, then victim choice
    look("R8", 20'h00300, 12'h00C, 0, 0);
    fill("R8", 20'h00400, 20'h00444, 6'h3F);
    for (int i = 0; i < N; i++) look("R8", 20'h00100 + 20'(i), 12'h020, 0, 0);
    look("R8", 20'h00300, 12'h020, 0, 0);
    look("R8", 20'h00400, 12'h020, 0, 0);

    // R8 R9: pseudo-random mix over sixteen pages
    seed = 32'h1234_5678;
    for (int k = 0; k < 1500; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step("R8", seed[16], {20'h00500 + 20'(seed[20:17]), seed[31:20]},
           seed[21], seed[22], seed[23] & seed[24],
           20'h00500 + 20'(seed[28:25]), {seed[15:0], seed[31:28]},
           {seed[5:2], 2'b11} | {1'b0, seed[29], 4'b0}, seed[11:6] == 6'd0);
    end
    idle("R1");
    summary();
  end
endmodule